// File: doc/BRIEF.md
# Segmented Capture Sequencer

The block divides one linear memory region into a programmable number of equal segments and fills them one after another with triggered captures. Inside each segment the capture works like a small circular recorder: a pre-trigger share of the segment is filled first, writing then continues around the segment until a trigger is taken, and after that the remaining share of the segment is written and the frame closes. The block drives a write address and a write strobe, one sample per clock, to an external write engine that it does not contain.

Each accepted trigger has its absolute memory address stored in an internal table indexed by frame number, so software can locate every frame afterwards. Between two frames the block spends exactly two clock cycles without writing before the next segment starts. Triggers that land while a frame cannot take them (pre-trigger fill or the inter-frame gap) are counted. After the final frame a done flag is raised and the block stays quiet until the next arm pulse.

Top module: `seg_capture_ctrl`

## Requirements
- R1: An arm pulse latches frame_count, seg_len and pre_depth, selects frame 0 with segment base 0, and the first write (wr_en=1, wr_addr=0) happens in the cycle after the arm is sampled. seg_len must be at least 1 and pre_depth below seg_len.
- R2: Frame f uses segment base f*seg_len; the k-th write of a frame goes to base + (k mod seg_len), so the offset wraps inside the segment.
- R3: During the first pre_depth writes of a frame a trigger is not taken; each such trigger adds one to the missed count.
- R4: After the pre-trigger fill a trigger is taken in the cycle it is seen; the sample written in that cycle is the first of seg_len - pre_depth post-trigger writes, and its absolute address is stored in the table entry of the current frame.
- R5: frame_done is high for exactly one cycle, the cycle after the last write of a frame; that cycle and the next carry no write, and the following cycle is the first write of the next frame with frame_idx incremented.
- R6: A trigger during the two-cycle gap between frames adds one to the missed count; arm clears the missed count.
- R7: After the last frame closes, seq_done is 1, no writes occur, and triggers neither start a capture nor change the missed count until the next arm.
- R8: tab_addr shows the table entry selected by tab_idx one cycle after tab_idx is sampled.
- R9: A frame_count of 0 runs one frame; a frame_count above MAX_FRAMES runs MAX_FRAMES frames.
- R10: The missed count stops at its all-ones value and does not wrap.
- R11: An arm pulse in any state aborts the running sequence, clears seq_done and the missed count, and restarts at frame 0.
- R12: After reset wr_en, frame_done and seq_done are 0, frame_idx is 0 and the missed count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start (or restart) a capture sequence |
| trig | input | 1 | Trigger event, one cycle per event |
| frame_count | input | FC_W | Number of frames to capture |
| seg_len | input | ADDR_W | Samples per segment |
| pre_depth | input | ADDR_W | Pre-trigger samples per frame |
| tab_idx | input | IDX_W | Frame number to read from the trigger table |
| wr_en | output | 1 | A sample is written this cycle |
| wr_addr | output | ADDR_W | Address of the sample written this cycle |
| seg_base | output | ADDR_W | Base address of the current segment |
| frame_idx | output | IDX_W | Current frame number |
| frame_done | output | 1 | One-cycle pulse after the last write of a frame |
| seq_done | output | 1 | All frames of the sequence are captured |
| missed | output | MISS_W | Count of triggers that could not be taken |
| tab_addr | output | ADDR_W | Stored trigger address of frame tab_idx |

## Verification
The bench builds the block with MAX_FRAMES=8, ADDR_W=12 and MISS_W=3. With eight frames the full sequence including the final frame, the clamp of an oversized frame_count (15 runs 8 frames) and the zero case are reached in a few hundred cycles, and a three-bit missed count reaches its saturation point after only seven rejected triggers. Segment lengths of 4 to 8 with wait times that push the trigger past the segment end exercise the offset wrap and the single-sample post-trigger case.

// File: rtl/seg_pkg.sv
// Shared definitions for the segmented capture sequencer.
package seg_pkg;

    // Phases of one capture sequence.
    typedef enum logic [2:0] {
        ST_IDLE,   // never armed since reset
        ST_FILL,   // writing pre-trigger samples, triggers rejected
        ST_HUNT,   // writing circularly, waiting for a trigger
        ST_POST,   // writing post-trigger samples
        ST_GAP,    // write-free cycles between frames
        ST_END     // all frames captured
    } seg_state_t;

    // Write-free cycles between the last write of a frame and the next frame.
    localparam int GAP_CYC = 2;

endpackage

// File: rtl/seg_sequencer.sv
// Frame sequencer: walks each frame through fill, hunt, post and gap phases
// and steps over the frames of a sequence.
// Assumes: seg_len >= 1 and pre_depth < seg_len at the arm pulse; one sample
// is written per cycle while wr_en is high.
module seg_sequencer
    import seg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_FRAMES = 4096,
    localparam int IDX_W     = $clog2(MAX_FRAMES),
    localparam int FC_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig,
    input  logic [FC_W-1:0]   frame_count,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic [ADDR_W-1:0] pre_depth,
    output logic              wr_en,
    output logic              trig_take,
    output logic              miss_evt,
    output logic              step_seg,
    output logic              frame_done,
    output logic              seq_done,
    output logic [IDX_W-1:0]  frame_idx,
    output logic [ADDR_W-1:0] seg_len_q
);

    localparam logic [FC_W-1:0] FC_MAX   = FC_W'(MAX_FRAMES);
    localparam logic [1:0]      GAP_LAST = 2'(GAP_CYC - 1);

    seg_state_t        state;
    logic [ADDR_W-1:0] pre_q;
    logic [ADDR_W-1:0] fill;
    logic [ADDR_W-1:0] post_rem;
    logic [ADDR_W-1:0] post_len;
    logic [1:0]        gap_cnt;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  last_in;

    // Index of the final frame, with 0 and oversized counts clamped.
    always_comb begin
        if (frame_count == '0)
            last_in = '0;
        else if (frame_count > FC_MAX)
            last_in = IDX_W'(MAX_FRAMES - 1);
        else
            last_in = IDX_W'(frame_count - 1'b1);
    end

    // Post-trigger sample count of every frame.
    assign post_len = seg_len_q - pre_q;

    // Write strobe and event decodes for the neighbours.
    assign wr_en     = (state == ST_FILL) || (state == ST_HUNT) || (state == ST_POST);
    assign trig_take = (state == ST_HUNT) && trig && !arm;
    assign miss_evt  = trig && !arm && ((state == ST_FILL) || (state == ST_GAP));
    assign step_seg  = (state == ST_GAP) && (gap_cnt == GAP_LAST) &&
                       (frame_idx != last_idx) && !arm;

    // Phase register, counters and sequence flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            seg_len_q  <= '0;
            pre_q      <= '0;
            fill       <= '0;
            post_rem   <= '0;
            gap_cnt    <= '0;
            last_idx   <= '0;
            frame_idx  <= '0;
            frame_done <= 1'b0;
            seq_done   <= 1'b0;
        end else if (arm) begin
            seg_len_q  <= seg_len;
            pre_q      <= pre_depth;
            last_idx   <= last_in;
            fill       <= '0;
            post_rem   <= '0;
            gap_cnt    <= '0;
            frame_idx  <= '0;
            frame_done <= 1'b0;
            seq_done   <= 1'b0;
            state      <= (pre_depth == '0) ? ST_HUNT : ST_FILL;
        end else begin
            frame_done <= 1'b0;
            case (state)
                ST_FILL: begin
                    if (fill == pre_q - 1'b1)
                        state <= ST_HUNT;
                    else
                        fill <= fill + 1'b1;
                end
                ST_HUNT: begin
                    if (trig) begin
                        if (post_len == ADDR_W'(1)) begin
                            state      <= ST_GAP;
                            frame_done <= 1'b1;
                            gap_cnt    <= '0;
                        end else begin
                            post_rem <= post_len - 1'b1;
                            state    <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    if (post_rem == ADDR_W'(1)) begin
                        state      <= ST_GAP;
                        frame_done <= 1'b1;
                        gap_cnt    <= '0;
                    end else begin
                        post_rem <= post_rem - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        gap_cnt <= '0;
                        if (frame_idx == last_idx) begin
                            state    <= ST_END;
                            seq_done <= 1'b1;
                        end else begin
                            frame_idx <= frame_idx + 1'b1;
                            fill      <= '0;
                            state     <= (pre_q == '0) ? ST_HUNT : ST_FILL;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: the frame-close pulse falls in a write-free cycle.
    a_r5_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !wr_en);

    // R5: the frame-close pulse lasts one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: a finished sequence writes nothing until re-armed.
    a_r7_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !arm) |=> (!wr_en && seq_done));

    // R3: a trigger during the fill never opens the post-trigger phase.
    a_r3_fill_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FILL) && !arm) |=> ((state == ST_FILL) || (state == ST_HUNT)));

    // R11: arm always lands in a writing phase of frame 0.
    a_r11_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (wr_en && (frame_idx == '0) && !seq_done));

endmodule

// File: rtl/seg_addr_gen.sv
// Address generator: holds the segment base and the offset inside it and
// forms the absolute write address.
// Assumes: seg_len is stable between restarts and non-zero while writing.
module seg_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              adv,
    input  logic [ADDR_W-1:0] seg_len,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] off,
    output logic [ADDR_W-1:0] addr
);

    // Absolute address of the current sample.
    assign addr = base + off;

    // Base steps by one segment per frame; offset wraps inside the segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            off  <= '0;
        end else if (restart) begin
            base <= '0;
            off  <= '0;
        end else if (step) begin
            base <= base + seg_len;
            off  <= '0;
        end else if (adv) begin
            off <= (off == seg_len - 1'b1) ? '0 : off + 1'b1;
        end
    end

    // R2: the offset never leaves the segment.
    a_r2_off_in_seg: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_len != '0) |-> (off < seg_len));

    // R1: a restart returns to the first address of the region.
    a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((base == '0) && (off == '0)));

endmodule

// File: rtl/trig_table.sv
// Trigger address table: one entry per frame, written when a trigger is taken,
// read through a registered port.
// Assumes: entries are only meaningful for frames whose trigger was taken.
module trig_table #(
    parameter int DEPTH  = 4096,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the trigger address of the current frame.
    always_ff @(posedge clk) begin
        if (we)
            mem[widx] <= wdata;
    end

    // Registered readback of the selected frame.
    always_ff @(posedge clk) begin
        rdata <= mem[ridx];
    end

endmodule

// File: rtl/miss_counter.sv
// Saturating counter of triggers that could not be taken.
// Assumes: at most one event per cycle; clear wins over an event.
module miss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count events, stop at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + 1'b1;
    end

    // R10: a full counter stays full.
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '1) && !clr) |=> (count == '1));

    // R6: the count moves by at most one per cycle unless cleared.
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

endmodule

// File: rtl/seg_capture_ctrl.sv
// Segmented capture sequencer top: splits a memory region into equal
// segments, captures one triggered frame per segment and records the
// trigger address of each frame.
// Assumes: the write engine takes one sample per cycle whenever wr_en is high.
module seg_capture_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int MAX_FRAMES = 4096,
    parameter int MISS_W     = 16,
    localparam int IDX_W     = $clog2(MAX_FRAMES),
    localparam int FC_W      = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              trig,
    input  logic [FC_W-1:0]   frame_count,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic [ADDR_W-1:0] pre_depth,
    input  logic [IDX_W-1:0]  tab_idx,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] seg_base,
    output logic [IDX_W-1:0]  frame_idx,
    output logic              frame_done,
    output logic              seq_done,
    output logic [MISS_W-1:0] missed,
    output logic [ADDR_W-1:0] tab_addr
);

    logic              trig_take;
    logic              miss_evt;
    logic              step_seg;
    logic [ADDR_W-1:0] seg_len_q;
    logic [ADDR_W-1:0] off;

    seg_sequencer #(
        .ADDR_W     (ADDR_W),
        .MAX_FRAMES (MAX_FRAMES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .trig        (trig),
        .frame_count (frame_count),
        .seg_len     (seg_len),
        .pre_depth   (pre_depth),
        .wr_en       (wr_en),
        .trig_take   (trig_take),
        .miss_evt    (miss_evt),
        .step_seg    (step_seg),
        .frame_done  (frame_done),
        .seq_done    (seq_done),
        .frame_idx   (frame_idx),
        .seg_len_q   (seg_len_q)
    );

    seg_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm),
        .step    (step_seg),
        .adv     (wr_en),
        .seg_len (seg_len_q),
        .base    (seg_base),
        .off     (off),
        .addr    (wr_addr)
    );

    trig_table #(
        .DEPTH  (MAX_FRAMES),
        .DATA_W (ADDR_W)
    ) u_tab (
        .clk   (clk),
        .we    (trig_take),
        .widx  (frame_idx),
        .wdata (wr_addr),
        .ridx  (tab_idx),
        .rdata (tab_addr)
    );

    miss_counter #(
        .W (MISS_W)
    ) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .inc   (miss_evt),
        .count (missed)
    );

endmodule

// File: tb/sim_seg_capture_ctrl.sv
// Scoreboard bench: the driver pushes expected write addresses, the monitor
// pops and compares them against every write the design makes.
module sim_seg_capture_ctrl;

    localparam int AW   = 12;
    localparam int MAXF = 8;
    localparam int MW   = 3;
    localparam int IW   = $clog2(MAXF);
    localparam int FW   = $clog2(MAXF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic          trig = 1'b0;
    logic [FW-1:0] frame_count = '0;
    logic [AW-1:0] seg_len = '0;
    logic [AW-1:0] pre_depth = '0;
    logic [IW-1:0] tab_idx = '0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] seg_base;
    logic [IW-1:0] frame_idx;
    logic          frame_done;
    logic          seq_done;
    logic [MW-1:0] missed;
    logic [AW-1:0] tab_addr;

    int nchk = 0;
    int nfail = 0;
    int fd_seen = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int expq[$];
    int exp_tab[MAXF];

    always #4 clk = ~clk;

    seg_capture_ctrl #(
        .ADDR_W     (AW),
        .MAX_FRAMES (MAXF),
        .MISS_W     (MW)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .trig        (trig),
        .frame_count (frame_count),
        .seg_len     (seg_len),
        .pre_depth   (pre_depth),
        .tab_idx     (tab_idx),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .seg_base    (seg_base),
        .frame_idx   (frame_idx),
        .frame_done  (frame_done),
        .seq_done    (seq_done),
        .missed      (missed),
        .tab_addr    (tab_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every write against the scoreboard queue.
    always @(negedge clk) begin
        if (mon_on && wr_en) begin
            if (expq.size() == 0)
                chk(1'b0, "R2 unexpected write", int'(wr_addr), -1);
            else begin
                int e;
                e = expq.pop_front();
                chk(int'(wr_addr) == e, "R2 write address", int'(wr_addr), e);
            end
        end
        if (mon_on && frame_done) fd_seen++;
    end

    // Driver: run one sequence with a fixed hunt wait per frame.
    task automatic cap(input int fc, input int nf, input int seg, input int pre,
                       input int w, input bit pk_pre, input bit pk_gap);
        int post;
        int tot;
        int emiss;
        post  = seg - pre;
        tot   = pre + w + post;
        emiss = nf * ((pk_pre && pre > 0) ? 1 : 0) + nf * (pk_gap ? 1 : 0);
        if (emiss > 7) emiss = 7;
        for (int f = 0; f < nf; f++) begin
            for (int k = 0; k < tot; k++) expq.push_back(f * seg + k % seg);
            exp_tab[f] = f * seg + (pre + w) % seg;
        end
        frame_count = FW'(fc);
        seg_len     = AW'(seg);
        pre_depth   = AW'(pre);
        fd_seen     = 0;
        mon_on      = 1'b1;
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        for (int f = 0; f < nf; f++) begin
            for (int c = 0; c < tot + 2; c++) begin
                trig = (c == pre + w) || (pk_pre && pre > 0 && c == 0) || (pk_gap && c == tot);
                if (c == 0) begin
                    chk(int'(frame_idx) == f, "R5 frame index at frame start", int'(frame_idx), f);
                    chk(int'(seg_base) == f * seg, "R2 segment base", int'(seg_base), f * seg);
                    chk(wr_en == 1'b1, "R1 first write of frame", int'(wr_en), 1);
                end
                if (c == tot)
                    chk(frame_done && !wr_en, "R5 close pulse in quiet cycle",
                        int'({frame_done, wr_en}), 2);
                if (c == tot + 1)
                    chk(!frame_done && !wr_en, "R5 second gap cycle",
                        int'({frame_done, wr_en}), 0);
                @(negedge clk);
            end
        end
        trig = 1'b0;
        chk(seq_done == 1'b1, "R7 sequence done", int'(seq_done), 1);
        chk(int'(missed) == emiss, "R3 R6 missed count", int'(missed), emiss);
        chk(expq.size() == 0, "R2 all writes seen", expq.size(), 0);
        chk(fd_seen == nf, "R5 close pulses", fd_seen, nf);
        for (int f = 0; f < nf; f++) begin
            tab_idx = IW'(f);
            @(negedge clk);
            chk(int'(tab_addr) == exp_tab[f], "R4 R8 trigger table", int'(tab_addr), exp_tab[f]);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int m;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!wr_en && !frame_done && !seq_done, "R12 reset flags",
            int'({wr_en, frame_done, seq_done}), 0);
        chk(frame_idx == '0 && missed == '0, "R12 reset counters",
            int'(frame_idx) + int'(missed), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R8: wrap past segment end, rejected triggers.
        cap(3, 3, 8, 3, 5, 1'b1, 1'b1);

        // R7: triggers after the last frame are ignored.
        m = int'(missed);
        trig = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!wr_en, "R7 no write after done", int'(wr_en), 0);
        end
        trig = 1'b0;
        chk(int'(missed) == m && seq_done, "R7 missed unchanged", int'(missed), m);

        // R11: arm clears flags, and a second arm aborts a running frame.
        mon_on = 1'b0;
        frame_count = FW'(2); seg_len = AW'(8); pre_depth = AW'(2);
        arm = 1'b1; @(negedge clk); arm = 1'b0;
        chk(!seq_done && missed == '0, "R11 arm clears done and missed",
            int'({seq_done, missed}), 0);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        repeat (2) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk(int'(missed) == 1, "R3 fill trigger counted", int'(missed), 1);
        frame_count = FW'(1); pre_depth = AW'(1); seg_len = AW'(4);
        arm = 1'b1; @(negedge clk); arm = 1'b0;
        chk(wr_en && wr_addr == '0 && frame_idx == '0 && missed == '0, "R11 abort restart",
            int'(wr_addr), 0);
        trig = 1'b1;
        repeat (12) @(negedge clk);
        trig = 1'b0;
        chk(seq_done == 1'b1, "R11 restarted sequence completes", int'(seq_done), 1);

        // R4 R5: no pre-trigger share, immediate trigger.
        cap(2, 2, 6, 0, 0, 1'b0, 1'b0);
        // R9: frame_count 0 runs one frame; one post-trigger sample.
        cap(0, 1, 5, 4, 2, 1'b1, 1'b0);
        // R9 R10: oversized count clamps to 8 frames; missed saturates.
        cap(15, 8, 4, 1, 1, 1'b1, 1'b1);
        chk(int'(frame_idx) == 7, "R9 last frame index", int'(frame_idx), 7);
        chk(missed == '1, "R10 saturated count", int'(missed), 7);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule